// File: doc/BRIEF.md
# LPC Memory Target Interface

This block is the target side of a Low Pin Count bus for a memory-mapped device. It samples the 4-bit LAD bus and the active-low frame strobe on every rising clock edge. It recognises a START nibble and then a memory cycle-type nibble, and it collects a 32-bit address. It compares the device-select address bits against a 4-bit strap. Once the device is selected, it turns the bus around, drives SYNC, and either returns or accepts one data byte.

Bit A22 of the address steers the access. Memory accesses become single-byte read or write requests to a back end, which answers with a ready handshake. Register accesses go to a small read-only window that holds three fixed identification bytes and the live state of the general-purpose input pins. While the back end is slow, the block drives long-wait SYNC nibbles, up to a configurable limit. A host abort is honoured in every phase of a cycle.

Top module: `lpc_mem_target`

## Requirements
- R1: A cycle starts when `lframe_ni` is low and LAD is 0000 at a rising edge. While the frame stays low with 0000 on LAD the block keeps waiting, so only the last START before the frame rises counts. The nibble sampled at the first edge with the frame high is the cycle type.
- R2: In the cycle-type nibble, bits 3:2 must be 01, bit 1 selects write (1) or read (0), and bit 0 is ignored. With any other value in bits 3:2 the block returns to idle, never drives LAD and issues no request.
- R3: The address arrives as eight nibbles, most significant first. The device is selected only when {A23,A21,A20,A19} equals the bitwise inverse of `id_strap_i`. On a mismatch the rest of the cycle is ignored: LAD is not driven and no request is made.
- R4: Read timing after the last address nibble: in the first clock LAD is floated; in the second the target drives 1111; then come the SYNC clocks, the low data nibble and the high data nibble. After that LAD is floated again.
- R5: Write timing after the address: the low data nibble, then the high data nibble, then one floated host turnaround clock, then the target drives 1111, then the SYNC clocks, then 1111 for one clock. After that LAD is floated.
- R6: When A22 is 1, `mem_req_o` rises in the clock after the last address nibble of a read, or after the last data nibble of a write. It stays high until a rising edge samples `mem_ready_i` high. `mem_addr_o` carries A18:A0, `mem_we_o` the direction and `mem_wdata_o` the written byte. For a read, the byte returned is the `mem_rdata_i` value sampled at that edge.
- R7: If ready was sampled at either turnaround edge, the first SYNC clock drives 0000. Otherwise the block drives 0110 in each SYNC clock up to the edge that samples ready, and 0000 in the clock after that edge.
- R8: After WAIT_MAX clocks of 0110 without ready, the block drops the request and drives 1010 as SYNC; a read then returns FFh. If ready arrives at the same edge as the expiry, ready wins.
- R9: When A22 is 0, the access goes to the register window, decoded on A15:A0. Offset 0000h reads 37h, 0001h reads 9Dh, 0003h reads 7Fh, and 0100h reads {000, gpi_i[4:0]}; every other offset reads 00h. Writes have no effect. SYNC is 0000 with no wait, and no back-end request is made.
- R10: While `busy_i` is high at the second turnaround edge, a register read returns 00h.
- R11: If the frame is low at an edge with a nibble other than 0000 in any phase of a cycle, LAD is floated from the next clock and any request is withdrawn. The block then ignores the bus until the frame is low with 1111 (return to idle) or with 0000 (a new START).
- R12: `lad_oe_o` is high only in the clocks where the target owns LAD, and it is low during and right after an asynchronous reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lframe_ni | input | 1 | Frame strobe, active low |
| lad_i | input | 4 | LAD value sampled from the bus |
| lad_o | output | 4 | LAD value driven by the target |
| lad_oe_o | output | 1 | LAD output enable |
| id_strap_i | input | 4 | Device identity strap |
| gpi_i | input | GPI_W | General-purpose input pins |
| busy_i | input | 1 | Internal program or erase in progress |
| mem_req_o | output | 1 | Back-end request |
| mem_we_o | output | 1 | Request direction, 1 for write |
| mem_addr_o | output | MEM_AW | Byte address in the array |
| mem_wdata_o | output | 8 | Byte to write |
| mem_ready_i | input | 1 | Back end accepts the request |
| mem_rdata_i | input | 8 | Read byte, valid with ready |

## Verification
Two events can land on the same rising edge: the back end's ready and the expiry of the long-wait limit. The bench provokes this by setting the ready latency to exactly one clock past the limit. It expects WAIT_MAX long-wait nibbles followed by a normal 0000 SYNC and the true data. One clock later, it expects the 1010 error SYNC and FFh. A second collision is a frame abort during a long wait: the next clock must show LAD floated and the request gone, and a fresh cycle right afterwards must complete.

// File: rtl/lpc_tgt_pkg.sv
package lpc_tgt_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_ADDR, ST_WLO, ST_WHI, ST_TAR0,
    ST_TAR1, ST_SYNC, ST_RLO, ST_RHI, ST_WTAR, ST_ABORT
  } lpc_st_e;

  localparam logic [3:0] NIB_START  = 4'h0;
  localparam logic [3:0] NIB_ABORT  = 4'hF;
  localparam logic [3:0] NIB_TAR    = 4'hF;
  localparam logic [3:0] SYNC_OK    = 4'h0;
  localparam logic [3:0] SYNC_LWAIT = 4'h6;
  localparam logic [3:0] SYNC_ERR   = 4'hA;
  localparam logic [1:0] TYPE_MEM   = 2'b01;
endpackage

// File: rtl/lpc_dev_select.sv
module lpc_dev_select #(
  parameter int ID_W = 4
) (
  input  logic [ID_W:0]   sel_bits_i,  // {A23,A22,A21,A20,A19}
  input  logic [ID_W-1:0] id_i,
  output logic            hit_o,
  output logic            mem_o
);
  logic [ID_W-1:0] dev_bits;
  assign dev_bits = {sel_bits_i[ID_W], sel_bits_i[ID_W-2:0]};
  assign hit_o    = (dev_bits == ~id_i);
  assign mem_o    = sel_bits_i[ID_W-1];
endmodule

// File: rtl/lpc_reg_window.sv
module lpc_reg_window #(
  parameter int         GPI_W   = 5,
  parameter logic [7:0] MFR_ID  = 8'h37,
  parameter logic [7:0] DEV_ID  = 8'h9D,
  parameter logic [7:0] CONT_ID = 8'h7F
) (
  input  logic [15:0]      off_i,
  input  logic [GPI_W-1:0] gpi_i,
  input  logic             busy_i,
  output logic [7:0]       data_o
);
  localparam int PAD_W = 8 - GPI_W;
  logic [7:0] gpi_byte;

  generate
    if (PAD_W > 0) begin : g_pad
      assign gpi_byte = {{PAD_W{1'b0}}, gpi_i};
    end else begin : g_nopad
      assign gpi_byte = gpi_i[7:0];
    end
  endgenerate

  always_comb begin
    data_o = 8'h00;
    if (!busy_i) begin
      unique case (off_i)
        16'h0000: data_o = MFR_ID;
        16'h0001: data_o = DEV_ID;
        16'h0003: data_o = CONT_ID;
        16'h0100: data_o = gpi_byte;
        default:  data_o = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/lpc_wait_ctrl.sv
module lpc_wait_ctrl #(
  parameter int WAIT_MAX = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       start_i,
  input  logic       reg_load_i,
  input  logic [7:0] reg_data_i,
  input  logic       in_sync_i,
  input  logic       mem_ready_i,
  input  logic [7:0] mem_rdata_i,
  output logic       req_o,
  output logic       done_o,
  output logic       err_o,
  output logic [7:0] rdata_o
);
  localparam int CW = $clog2(WAIT_MAX + 1);
  localparam logic [CW-1:0] WLAST = CW'(WAIT_MAX - 1);

  logic          pend_q, done_q, err_q;
  logic [CW-1:0] wcnt_q;
  logic [7:0]    rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0;
      wcnt_q <= '0;   rdata_q <= 8'h00;
    end else if (clr_i) begin
      pend_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0;
      wcnt_q <= '0;
    end else if (start_i) begin
      pend_q <= 1'b1; done_q <= 1'b0; err_q <= 1'b0;
      wcnt_q <= '0;
    end else if (reg_load_i) begin
      done_q  <= 1'b1;
      rdata_q <= reg_data_i;
    end else if (pend_q && mem_ready_i) begin
      // ready beats an expiry on the same edge
      pend_q  <= 1'b0;
      done_q  <= 1'b1;
      rdata_q <= mem_rdata_i;
    end else if (pend_q && in_sync_i) begin
      if (wcnt_q == WLAST) begin
        pend_q  <= 1'b0;
        err_q   <= 1'b1;
        rdata_q <= 8'hFF;
      end else begin
        wcnt_q <= wcnt_q + 1'b1;
      end
    end
  end

  assign req_o   = pend_q;
  assign done_o  = done_q;
  assign err_o   = err_q;
  assign rdata_o = rdata_q;

  // R8
  wait_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wcnt_q < CW'(WAIT_MAX));
  // R6
  req_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && mem_ready_i && !clr_i) |=> (!req_o && done_o));
  // R8
  err_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> !req_o);
endmodule

// File: rtl/lpc_mem_target.sv
module lpc_mem_target
  import lpc_tgt_pkg::*;
#(
  parameter int         MEM_AW   = 19,
  parameter int         GPI_W    = 5,
  parameter int         WAIT_MAX = 8,
  parameter logic [7:0] MFR_ID   = 8'h37,
  parameter logic [7:0] DEV_ID   = 8'h9D,
  parameter logic [7:0] CONT_ID  = 8'h7F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lframe_ni,
  input  logic [3:0]        lad_i,
  output logic [3:0]        lad_o,
  output logic              lad_oe_o,
  input  logic [3:0]        id_strap_i,
  input  logic [GPI_W-1:0]  gpi_i,
  input  logic              busy_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic [7:0]        mem_rdata_i
);
  localparam int ADDR_NIBS = 8;
  localparam int NC_W      = $clog2(ADDR_NIBS);
  localparam int AQ_W      = 24;  // A31:A24 carry no decode
  localparam logic [NC_W-1:0] NIB_LAST = NC_W'(ADDR_NIBS - 1);

  lpc_st_e           st_q, st_d;
  logic [NC_W-1:0]   nib_cnt_q;
  logic [AQ_W-1:0]   addr_q, addr_nxt;
  logic              wr_q, mem_q;
  logic [7:0]        wdata_q;
  logic              sel_hit, sel_mem, last_nib;
  logic [7:0]        reg_data, rdata;
  logic              done, err, start_req, reg_load;

  assign addr_nxt = {addr_q[AQ_W-5:0], lad_i};
  assign last_nib = (st_q == ST_ADDR) && (nib_cnt_q == NIB_LAST);

  lpc_dev_select #(.ID_W(4)) u_sel (
    .sel_bits_i (addr_nxt[23:19]),
    .id_i       (id_strap_i),
    .hit_o      (sel_hit),
    .mem_o      (sel_mem)
  );

  lpc_reg_window #(
    .GPI_W(GPI_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID), .CONT_ID(CONT_ID)
  ) u_regs (
    .off_i  (addr_q[15:0]),
    .gpi_i  (gpi_i),
    .busy_i (busy_i),
    .data_o (reg_data)
  );

  assign start_req = lframe_ni &&
                     ((last_nib && sel_hit && sel_mem && !wr_q) ||
                      (st_q == ST_WHI && mem_q));
  assign reg_load  = lframe_ni && (st_q == ST_TAR1) && !mem_q;

  lpc_wait_ctrl #(.WAIT_MAX(WAIT_MAX)) u_wait (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (!lframe_ni),
    .start_i     (start_req),
    .reg_load_i  (reg_load),
    .reg_data_i  (reg_data),
    .in_sync_i   (st_q == ST_SYNC),
    .mem_ready_i (mem_ready_i),
    .mem_rdata_i (mem_rdata_i),
    .req_o       (mem_req_o),
    .done_o      (done),
    .err_o       (err),
    .rdata_o     (rdata)
  );

  always_comb begin
    st_d = st_q;
    if (!lframe_ni) begin
      if (lad_i == NIB_START)      st_d = ST_START;
      else if (lad_i == NIB_ABORT) st_d = ST_IDLE;
      else if (st_q == ST_IDLE)    st_d = ST_IDLE;
      else                         st_d = ST_ABORT;
    end else begin
      unique case (st_q)
        ST_START: st_d = (lad_i[3:2] == TYPE_MEM) ? ST_ADDR : ST_IDLE;
        ST_ADDR: if (last_nib)
                   st_d = !sel_hit ? ST_IDLE : (wr_q ? ST_WLO : ST_TAR0);
        ST_WLO:  st_d = ST_WHI;
        ST_WHI:  st_d = ST_TAR0;
        ST_TAR0: st_d = ST_TAR1;
        ST_TAR1: st_d = ST_SYNC;
        ST_SYNC: if (done || err) st_d = wr_q ? ST_WTAR : ST_RLO;
        ST_RLO:  st_d = ST_RHI;
        ST_RHI:  st_d = ST_IDLE;
        ST_WTAR: st_d = ST_IDLE;
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      nib_cnt_q <= '0;
      addr_q    <= '0;
      wr_q      <= 1'b0;
      mem_q     <= 1'b0;
      wdata_q   <= 8'h00;
    end else begin
      st_q <= st_d;
      if (lframe_ni) begin
        unique case (st_q)
          ST_START: begin
            nib_cnt_q <= '0;
            wr_q      <= lad_i[1];
          end
          ST_ADDR: begin
            nib_cnt_q <= nib_cnt_q + 1'b1;
            addr_q    <= addr_nxt;
            if (last_nib) mem_q <= sel_mem;
          end
          ST_WLO:  wdata_q[3:0] <= lad_i;
          ST_WHI:  wdata_q[7:4] <= lad_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    lad_oe_o = 1'b1;
    unique case (st_q)
      ST_TAR1: lad_o = NIB_TAR;
      ST_SYNC: lad_o = done ? SYNC_OK : (err ? SYNC_ERR : SYNC_LWAIT);
      ST_RLO:  lad_o = rdata[3:0];
      ST_RHI:  lad_o = rdata[7:4];
      ST_WTAR: lad_o = NIB_TAR;
      default: begin lad_o = 4'h0; lad_oe_o = 1'b0; end
    endcase
  end

  assign mem_we_o    = wr_q;
  assign mem_addr_o  = addr_q[MEM_AW-1:0];
  assign mem_wdata_o = wdata_q;

  // R11
  abort_float_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lframe_ni |=> !lad_oe_o);
  // R2
  bad_type_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_START && lframe_ni && lad_i[3:2] != TYPE_MEM) |=> (!lad_oe_o && !mem_req_o));
  // R3
  id_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_nib && lframe_ni && !sel_hit) |=> (!mem_req_o && st_q == ST_IDLE));
  // R7
  lwait_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lad_oe_o && lad_o == SYNC_LWAIT && lframe_ni) |=> lad_oe_o);
  // R9
  reg_noreq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SYNC && !mem_q) |-> !mem_req_o);
endmodule

// File: tb/lpc_mem_target_tb.sv
`timescale 1ns/1ps
module lpc_mem_target_tb;
  localparam int W = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic lframe_ni = 1'b1;
  logic [3:0] lad_i = 4'hF;
  logic [3:0] id_strap_i = 4'h0;
  logic [4:0] gpi_i = 5'h00;
  logic busy_i = 1'b0;
  logic mem_ready_i = 1'b0;
  logic [7:0] mem_rdata_i = 8'h00;
  logic [3:0] lad_o;
  logic lad_oe_o, mem_req_o, mem_we_o;
  logic [18:0] mem_addr_o;
  logic [7:0] mem_wdata_o;

  always #2.5 clk_i = ~clk_i;

  lpc_mem_target #(.WAIT_MAX(W)) u_dut (
    .clk_i, .rst_ni, .lframe_ni, .lad_i, .lad_o, .lad_oe_o, .id_strap_i,
    .gpi_i, .busy_i, .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .mem_ready_i, .mem_rdata_i
  );

  int checks = 0, fails = 0;
  bit pend = 0;
  bit exp_oe;
  logic [3:0] exp_v;
  string ptag;
  int lat = 0, rcnt = 0, acc_cnt = 0;
  logic acc_we;
  logic [18:0] acc_addr;
  logic [7:0] acc_wd;

  function automatic logic [7:0] mem_model(input logic [18:0] a);
    return a[7:0] ^ 8'hA5;
  endfunction

  function automatic logic [31:0] mk_addr(input logic [3:0] id, input logic mem,
                                          input logic [18:0] off);
    logic [31:0] a;
    a = 32'hFF00_0000;
    a[23] = ~id[3];
    a[22] = mem;
    a[21:19] = ~id[2:0];
    a[18:0] = off;
    return a;
  endfunction

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  // one clock: check outputs of the last edge, model the back end, drive the bus
  task automatic step(input logic f, input logic [3:0] n, input bit eo,
                      input logic [3:0] ev, input string t);
    @(negedge clk_i);
    if (pend) begin
      checks++;
      if (lad_oe_o !== exp_oe || (exp_oe && lad_o !== exp_v)) begin
        fails++;
        $display("FAIL %s: actual oe=%b lad=%h expected oe=%b lad=%h",
                 ptag, lad_oe_o, lad_o, exp_oe, exp_v);
      end
    end
    if (mem_req_o) rcnt++; else rcnt = 0;
    mem_ready_i = mem_req_o && (rcnt > lat);
    mem_rdata_i = mem_model(mem_addr_o);
    if (mem_req_o && mem_ready_i) begin
      acc_cnt++; acc_we = mem_we_o; acc_addr = mem_addr_o; acc_wd = mem_wdata_o;
    end
    lframe_ni = f; lad_i = n;
    pend = 1; exp_oe = eo; exp_v = ev; ptag = t;
  endtask

  // waits and error expected for a back end answering at the (lt+1)th edge
  task automatic wait_model(input int lt, output int nw, output bit er);
    if (lt > W + 1) begin nw = W; er = 1; end
    else begin nw = (lt >= 2) ? lt - 1 : 0; er = 0; end
  endtask

  task automatic hdr(input logic [3:0] ct, input logic [31:0] a);
    step(1'b0, 4'h0, 0, 4'h0, "R1 start");
    step(1'b1, ct, 0, 4'h0, "R2 type");
    for (int i = 7; i >= 0; i--) step(1'b1, a[i*4 +: 4], 0, 4'h0, "R3 address");
  endtask

  task automatic sync_seq(input int nw, input bit er, input string t);
    for (int k = 0; k < nw; k++) step(1'b1, 4'hF, 1, 4'h6, t);
    step(1'b1, 4'hF, 1, er ? 4'hA : 4'h0, t);
  endtask

  task automatic do_read(input logic [3:0] ct, input logic [31:0] a, input int lt,
                         input int nw, input bit er, input logic [7:0] d, input string t);
    lat = lt;
    hdr(ct, a);
    step(1'b1, 4'hF, 1, 4'hF, "R4 turnaround");
    sync_seq(nw, er, t);
    step(1'b1, 4'hF, 1, d[3:0], t);
    step(1'b1, 4'hF, 1, d[7:4], t);
    step(1'b1, 4'hF, 0, 4'h0, "R12 release after read");
  endtask

  task automatic do_write(input logic [31:0] a, input logic [7:0] d, input int lt,
                          input int nw, input string t);
    lat = lt;
    hdr(4'h6, a);
    step(1'b1, d[3:0], 0, 4'h0, "R5 data lo");
    step(1'b1, d[7:4], 0, 4'h0, "R5 data hi");
    step(1'b1, 4'hF, 1, 4'hF, "R5 turnaround");
    sync_seq(nw, 1'b0, t);
    step(1'b1, 4'hF, 1, 4'hF, "R5 closing 1111");
    step(1'b1, 4'hF, 0, 4'h0, "R12 release after write");
  endtask

  task automatic mem_read(input logic [18:0] off, input int lt, input string t);
    int nw; bit er;
    wait_model(lt, nw, er);
    do_read(4'h4, mk_addr(id_strap_i, 1'b1, off), lt, nw, er,
            er ? 8'hFF : mem_model(off), t);
  endtask

  task automatic reg_read(input logic [15:0] off, input logic [7:0] d, input string t);
    int n0;
    n0 = acc_cnt;
    do_read(4'h4, mk_addr(id_strap_i, 1'b0, {3'b000, off}), 0, 0, 1'b0, d, t);
    chk({t, " no request"}, acc_cnt, n0);
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL R12 watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n0;
    repeat (3) @(negedge clk_i);
    chk("R12 reset oe", lad_oe_o, 0);
    chk("R12 reset req", mem_req_o, 0);
    rst_ni = 1'b1;

    // R4 R6 R7 memory reads at several latencies
    mem_read(19'h01234, 0, "R7 read ready at tar0");
    mem_read(19'h00ABC, 1, "R7 read ready at tar1");
    mem_read(19'h7FFFF, 4, "R7 read long wait");
    // R8 ready on the expiry edge, then one clock late
    mem_read(19'h00010, W + 1, "R8 ready at expiry wins");
    mem_read(19'h00011, W + 2, "R8 wait limit error");
    chk("R8 request dropped", mem_req_o, 0);

    // R1 repeated START, R2 bit0 ignored
    step(1'b0, 4'h0, 0, 4'h0, "R1 repeated start");
    step(1'b0, 4'h0, 0, 4'h0, "R1 repeated start");
    do_read(4'h5, mk_addr(4'h0, 1'b1, 19'h00456), 0, 0, 1'b0,
            mem_model(19'h00456), "R2 bit0 ignored read");

    // R5 R6 memory writes
    do_write(mk_addr(4'h0, 1'b1, 19'h05A5A), 8'h3C, 0, 0, "R5 write sync");
    chk("R6 write we", acc_we, 1);
    chk("R6 write addr", acc_addr, 19'h05A5A);
    chk("R6 write data", acc_wd, 8'h3C);
    do_write(mk_addr(4'h0, 1'b1, 19'h40001), 8'hC7, 3, 2, "R7 write long wait");
    chk("R6 write addr 2", acc_addr, 19'h40001);
    chk("R6 write data 2", acc_wd, 8'hC7);

    // R9 register window
    gpi_i = 5'h15;
    reg_read(16'h0000, 8'h37, "R9 manufacturer id");
    reg_read(16'h0001, 8'h9D, "R9 device id");
    reg_read(16'h0003, 8'h7F, "R9 continuation id");
    reg_read(16'h0100, 8'h15, "R9 gpi");
    reg_read(16'h0002, 8'h00, "R9 unused offset");
    reg_read(16'h0101, 8'h00, "R9 unused offset 2");
    n0 = acc_cnt;
    do_write(mk_addr(4'h0, 1'b0, 19'h00000), 8'h00, 0, 0, "R9 register write");
    chk("R9 register write no request", acc_cnt, n0);
    reg_read(16'h0000, 8'h37, "R9 id unchanged after write");

    // R10 busy
    busy_i = 1'b1;
    reg_read(16'h0000, 8'h00, "R10 busy register read");
    busy_i = 1'b0;

    // R2 non-memory cycle type
    n0 = acc_cnt;
    step(1'b0, 4'h0, 0, 4'h0, "R1 start");
    step(1'b1, 4'h0, 0, 4'h0, "R2 bad type");
    for (int i = 0; i < 14; i++) step(1'b1, 4'h0, 0, 4'h0, "R2 ignored");
    chk("R2 bad type no request", acc_cnt, n0);

    // R3 id strap and mismatch
    id_strap_i = 4'h5;
    mem_read(19'h00077, 0, "R3 strap 0101 read");
    n0 = acc_cnt;
    hdr(4'h4, mk_addr(4'h4, 1'b1, 19'h00077));
    for (int i = 0; i < 10; i++) step(1'b1, 4'hF, 0, 4'h0, "R3 mismatch ignored");
    chk("R3 mismatch no request", acc_cnt, n0);
    id_strap_i = 4'h0;

    // R11 abort during address
    step(1'b0, 4'h0, 0, 4'h0, "R1 start");
    step(1'b1, 4'h4, 0, 4'h0, "R2 type");
    step(1'b1, 4'hF, 0, 4'h0, "R3 address");
    step(1'b0, 4'h5, 0, 4'h0, "R11 abort");
    for (int i = 0; i < 12; i++) step(1'b1, 4'h0, 0, 4'h0, "R11 aborted bus ignored");
    step(1'b0, 4'hF, 0, 4'h0, "R11 abort nibble");
    mem_read(19'h00123, 0, "R11 read after abort");

    // R11 abort during long wait
    lat = 1000;
    hdr(4'h4, mk_addr(4'h0, 1'b1, 19'h00321));
    step(1'b1, 4'hF, 1, 4'hF, "R4 turnaround");
    step(1'b1, 4'hF, 1, 4'h6, "R7 wait");
    step(1'b1, 4'hF, 1, 4'h6, "R7 wait");
    step(1'b0, 4'h3, 0, 4'h0, "R11 abort in sync");
    step(1'b1, 4'hF, 0, 4'h0, "R11 floated");
    chk("R11 request withdrawn", mem_req_o, 0);
    step(1'b0, 4'hF, 0, 4'h0, "R11 abort nibble");
    mem_read(19'h00321, 2, "R11 read after sync abort");

    step(1'b1, 4'hF, 0, 4'h0, "R12 idle");
    step(1'b1, 4'hF, 0, 4'h0, "R12 idle");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule